// File: doc/BRIEF.md
# Delayed ADC Pretrigger Sequencer

This block turns one external start pulse, typically a PWM reload event, into a timed series of ADC conversion requests. The start pulse zeroes an internal counter and sets it running up to a programmable modulus. Each of up to eight request channels carries its own compare value and issues a one-cycle trigger strobe, tagged with its channel index, when the running count reaches that value. Any channel other than channel 0 can instead be chained. It then ignores its compare value and issues as soon as the ADC reports that the conversion started by the channel just below it has finished.

Compare values and the modulus are written into shadow copies. They only become active when software issues a load command while the counter is already enabled, so a whole new schedule takes effect at once. The counter either runs once per start pulse or restarts by itself at the modulus. A sticky error flag reports any strobe issued while an earlier conversion is still outstanding.

Top module: `adc_pretrig_seq`

## Requirements
- R1: A start pulse sampled high while run enable is set zeroes the counter and starts it. A start that arrives during a run restarts the count from zero and discards channel requests not yet issued.
- R2: Take the rising edge that samples the start pulse as edge 0. A channel with active compare value D, not chained, drives `pt_strobe` high with `pt_idx` equal to its number in the cycle that follows edge D+1. A value of 0 therefore fires right after edge 1.
- R3: The counter holds each value from 0 up to the active modulus M for one cycle. In one-shot mode it then stops until the next start pulse. A compare value equal to M fires once per run, and a value above M never fires.
- R4: A channel is issued only when its enable bit (register 2) and its output-enable bit (register 3) are both set, with bit n belonging to channel n.
- R5: When the chain bit of channel n (register 4, bit n, n ≥ 1) is set, its compare value is ignored. It issues in the cycle after the edge that samples `conv_done` high, provided the most recent strobe came from channel n-1.
- R6: Compare values (register 8+n for channel n) and the modulus (register 1) are written to shadows. They are copied to the active set only by writing register 0 with bit 2 set while run enable is already set. A load written while run enable is clear is discarded.
- R7: Register 0 bit 0 is run enable and bit 1 selects continuous mode. In continuous mode the counter wraps from M back to 0 without a new start pulse, so a channel fires every M+1 cycles.
- R8: `seq_err` sets on the edge that issues a strobe while the previous strobe's conversion has not been reported done, unless `conv_done` is sampled on that same edge. It stays set until a write to register 5 with bit 0 set, and a write with bit 0 clear leaves it set.
- R9: At most one strobe is issued per clock. When several channels request together, the lowest index is issued first and the others follow on later cycles in index order.
- R10: The chain bit of channel 0 has no effect. Channel 0 always fires on its compare value.
- R11: During and just after reset, `pt_strobe`, `pt_idx` and `seq_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| start_trig | input | 1 | External start pulse |
| conv_done | input | 1 | ADC reports that the current conversion has finished |
| pt_strobe | output | 1 | One-cycle pretrigger strobe to the ADC |
| pt_idx | output | 3 | Index of the channel being issued |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The bench goes after off-by-one timing at both ends of the range. A compare value of zero, one equal to the modulus and one just above it catch a counter that skips its first or last value or fails to stop. It programs shadow values and loads them while run enable is clear, which a design that ignores the enable gate would apply early. Two channels with equal compare values expose a design that drops the losing channel instead of deferring it. A chained channel whose compare value coincides with an earlier channel's would fire early if its delay were not ignored. Finally, the error flag is checked for both setting and clearing: a design that sets it even when completion arrives in time, or clears it on a write of zero, shows a wrong flag.

// File: rtl/adc_pretrig_pkg.sv
// Shared constants for the pretrigger sequencer: register address map and
// bit positions inside the control word. Assumes at most 8 channels so that
// the per-channel compare registers fit at addresses 8..15.
package adc_pretrig_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL     = 5'd0;
    localparam logic [ADDR_W-1:0] A_MOD      = 5'd1;
    localparam logic [ADDR_W-1:0] A_EN       = 5'd2;
    localparam logic [ADDR_W-1:0] A_OE       = 5'd3;
    localparam logic [ADDR_W-1:0] A_CHAIN    = 5'd4;
    localparam logic [ADDR_W-1:0] A_ERRCLR   = 5'd5;
    localparam int                A_DLY_BASE = 8;

    localparam int B_RUN  = 0;
    localparam int B_CONT = 1;
    localparam int B_LOAD = 2;
endpackage

// File: rtl/adc_pretrig_regs.sv
// Register file of the sequencer. Holds control bits, per-channel enable,
// output-enable and chain masks, and shadow/active copies of the modulus and
// compare values. A load command copies shadows to the active set only while
// run enable is already set. Assumes NUM_PT <= 8 and CNT_W <= 16.
module adc_pretrig_regs
    import adc_pretrig_pkg::*;
#(
    parameter int NUM_PT = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic                          run_en,
    output logic                          cont_en,
    output logic [NUM_PT-1:0]             ch_en,
    output logic [NUM_PT-1:0]             ch_oe,
    output logic [NUM_PT-1:0]             ch_chain,
    output logic [CNT_W-1:0]              mod_act,
    output logic [NUM_PT-1:0][CNT_W-1:0]  dly_act,
    output logic                          err_clr
);
    logic                         ctrl_wr;
    logic                         load_ok;
    logic [CNT_W-1:0]             mod_shd;
    logic [NUM_PT-1:0][CNT_W-1:0] dly_shd;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign load_ok = ctrl_wr && wr_data[B_LOAD] && run_en;
    assign err_clr = wr_en && (wr_addr == A_ERRCLR) && wr_data[0];

    // Control bits and channel masks, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            cont_en  <= 1'b0;
            ch_en    <= '0;
            ch_oe    <= '0;
            ch_chain <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                run_en  <= wr_data[B_RUN];
                cont_en <= wr_data[B_CONT];
            end
            if (wr_addr == A_EN)    ch_en    <= wr_data[NUM_PT-1:0];
            if (wr_addr == A_OE)    ch_oe    <= wr_data[NUM_PT-1:0];
            if (wr_addr == A_CHAIN) ch_chain <= wr_data[NUM_PT-1:0];
        end
    end

    // Modulus shadow and its active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_shd <= '0;
            mod_act <= '0;
        end else begin
            if (wr_en && (wr_addr == A_MOD)) mod_shd <= wr_data[CNT_W-1:0];
            if (load_ok)                     mod_act <= mod_shd;
        end
    end

    // One shadow/active pair per channel compare value.
    for (genvar n = 0; n < NUM_PT; n++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_shd[n] <= '0;
                dly_act[n] <= '0;
            end else begin
                if (wr_en && (wr_addr == ADDR_W'(A_DLY_BASE + n)))
                    dly_shd[n] <= wr_data[CNT_W-1:0];
                if (load_ok)
                    dly_act[n] <= dly_shd[n];
            end
        end
    end

    AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_addr == A_CTRL) && wr_data[B_LOAD] && !run_en)
        |-> (mod_act == $past(mod_act)) && (dly_act == $past(dly_act))); // R6

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(wr_en && (wr_addr == A_CTRL))) |-> $stable(mod_act)); // R6
endmodule

// File: rtl/adc_pretrig_counter.sv
// Delay counter. A start pulse (with run enable set) zeroes the count and sets
// it running. It counts up to the active modulus, then either stops
// (one-shot) or wraps to zero (continuous). Clearing run enable stops it.
// Assumes the modulus may change mid-run, so wrap uses >= for safety.
module adc_pretrig_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cont_en,
    input  logic             start,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running
);
    logic at_end;

    assign at_end = (cnt >= mod_val);

    // Count sequencing: restart, step, wrap or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (!run_en) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (at_end) begin
                if (cont_en) cnt     <= '0;
                else         running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && run_en) |-> (cnt == '0) && running); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(running) && running && !$past(start)
        |-> (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)); // R3
endmodule

// File: rtl/adc_pretrig_issue.sv
// Request builder and issue stage. Each channel requests either on a compare
// match of the running count or, when chained, on conversion completion of
// the channel below it. Requests are held pending and issued lowest index
// first, one per clock, as a registered strobe plus index. Tracks the one
// outstanding conversion and raises a sticky sequence error on overlap.
module adc_pretrig_issue #(
    parameter int NUM_PT = 8,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          running,
    input  logic [CNT_W-1:0]              cnt,
    input  logic [NUM_PT-1:0][CNT_W-1:0]  dly_act,
    input  logic [NUM_PT-1:0]             ch_en,
    input  logic [NUM_PT-1:0]             ch_oe,
    input  logic [NUM_PT-1:0]             ch_chain,
    input  logic                          start,
    input  logic                          conv_done,
    input  logic                          err_clr,
    output logic                          trig_valid,
    output logic [IDX_W-1:0]              trig_idx,
    output logic                          seq_err
);
    logic [NUM_PT-1:0] live;
    logic [NUM_PT-1:0] use_dly;
    logic [NUM_PT-1:0] chain_hit;
    logic [NUM_PT-1:0] req_new;
    logic [NUM_PT-1:0] req;
    logic [NUM_PT-1:0] pend;
    logic [NUM_PT-1:0] grant;
    logic [IDX_W-1:0]  gidx;
    logic              any_req;
    logic              busy;
    logic [IDX_W-1:0]  busy_idx;

    // Per-channel request sources; channel 0 can never be chained.
    for (genvar n = 0; n < NUM_PT; n++) begin : g_req
        assign live[n] = ch_en[n] & ch_oe[n];
        if (n == 0) begin : g_first
            assign use_dly[n]   = 1'b1;
            assign chain_hit[n] = 1'b0;
        end else begin : g_rest
            assign use_dly[n]   = ~ch_chain[n];
            assign chain_hit[n] = ch_chain[n] & conv_done & busy &
                                  (busy_idx == IDX_W'(n - 1));
        end
        assign req_new[n] = live[n] &
                            ((running & use_dly[n] & (cnt == dly_act[n])) |
                             chain_hit[n]);
    end

    assign req     = pend | req_new;
    assign any_req = |req;

    // Fixed priority: lowest requesting index wins.
    always_comb begin
        grant = '0;
        gidx  = '0;
        for (int i = NUM_PT - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                gidx  = IDX_W'(i);
            end
        end
    end

    // Registered strobe, pending set and outstanding-conversion tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_valid <= 1'b0;
            trig_idx   <= '0;
            pend       <= '0;
            busy       <= 1'b0;
            busy_idx   <= '0;
        end else begin
            trig_valid <= any_req;
            if (any_req) trig_idx <= gidx;
            pend <= start ? '0 : (req & ~grant);
            if (any_req) begin
                busy     <= 1'b1;
                busy_idx <= gidx;
            end else if (conv_done) begin
                busy <= 1'b0;
            end
        end
    end

    // Sticky sequence error: set on overlapping issue, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                             seq_err <= 1'b0;
        else if (any_req && busy && !conv_done) seq_err <= 1'b1;
        else if (err_clr)                       seq_err <= 1'b0;
    end

    logic [NUM_PT-1:0] sel_oh;
    assign sel_oh = NUM_PT'(1) << trig_idx;

    AST_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (($past(ch_en & ch_oe) & sel_oh) != '0)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_err) && !$past(err_clr) |-> seq_err); // R8

    AST_ERR_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> trig_valid); // R8
endmodule

// File: rtl/adc_pretrig_seq.sv
// Top of the delayed ADC pretrigger sequencer. Wires the register file, the
// delay counter and the issue stage. Assumes start_trig and conv_done are
// synchronous to clk and one or more cycles wide as seen by the caller.
module adc_pretrig_seq
    import adc_pretrig_pkg::*;
#(
    parameter int NUM_PT = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_trig,
    input  logic              conv_done,
    output logic              pt_strobe,
    output logic [IDX_W-1:0]  pt_idx,
    output logic              seq_err
);
    logic                         run_en;
    logic                         cont_en;
    logic [NUM_PT-1:0]            ch_en;
    logic [NUM_PT-1:0]            ch_oe;
    logic [NUM_PT-1:0]            ch_chain;
    logic [CNT_W-1:0]             mod_act;
    logic [NUM_PT-1:0][CNT_W-1:0] dly_act;
    logic                         err_clr;
    logic [CNT_W-1:0]             cnt;
    logic                         running;
    logic                         start_ok;

    assign start_ok = start_trig && run_en;

    adc_pretrig_regs #(.NUM_PT(NUM_PT), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .run_en   (run_en),
        .cont_en  (cont_en),
        .ch_en    (ch_en),
        .ch_oe    (ch_oe),
        .ch_chain (ch_chain),
        .mod_act  (mod_act),
        .dly_act  (dly_act),
        .err_clr  (err_clr)
    );

    adc_pretrig_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .cont_en (cont_en),
        .start   (start_trig),
        .mod_val (mod_act),
        .cnt     (cnt),
        .running (running)
    );

    adc_pretrig_issue #(.NUM_PT(NUM_PT), .CNT_W(CNT_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .cnt        (cnt),
        .dly_act    (dly_act),
        .ch_en      (ch_en),
        .ch_oe      (ch_oe),
        .ch_chain   (ch_chain),
        .start      (start_ok),
        .conv_done  (conv_done),
        .err_clr    (err_clr),
        .trig_valid (pt_strobe),
        .trig_idx   (pt_idx),
        .seq_err    (seq_err)
    );
endmodule

// File: tb/adc_pretrig_seq_tb.sv
`timescale 1ns/1ps
module adc_pretrig_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        start_trig = 1'b0;
    logic        conv_done = 1'b0;
    logic        pt_strobe;
    logic [2:0]  pt_idx;
    logic        seq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    adc_pretrig_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_trig(start_trig), .conv_done(conv_done),
        .pt_strobe(pt_strobe), .pt_idx(pt_idx), .seq_err(seq_err)
    );

    // Table: channel, compare value, expected first strobe edge (0 = none). Modulus 40.
    localparam int TBL_N = 6;
    localparam int TBL_CH  [TBL_N] = '{0, 2, 5, 7, 3, 1};
    localparam int TBL_DLY [TBL_N] = '{0, 1, 17, 40, 41, 12};
    localparam int TBL_EXP [TBL_N] = '{1, 2, 18, 41, 0, 13};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start();
        start_trig = 1'b1;
        @(posedge clk); @(negedge clk);
        start_trig = 1'b0;
    endtask

    task automatic pulse_done();
        conv_done = 1'b1;
        @(posedge clk); @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Scan n edges after the start edge; report first strobe edge, its index and count.
    task automatic scan(input int n, output int first, output int fidx, output int cnt);
        first = 0; fidx = -1; cnt = 0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); @(negedge clk);
            if (pt_strobe) begin
                if (cnt == 0) begin first = k; fidx = int'(pt_idx); end
                cnt++;
            end
        end
    endtask

    task automatic settle();
        wr(5'd4, 16'h0);
        pulse_done();
        wr(5'd5, 16'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int first, fidx, cnt;
        int ks [4];
        int nk;
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R11: reset state
        check(pt_strobe == 1'b0, "R11", "strobe in reset", pt_strobe, 0);
        check(pt_idx == 3'd0, "R11", "index in reset", pt_idx, 0);
        check(seq_err == 1'b0, "R11", "error in reset", seq_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pt_strobe == 1'b0, "R11", "strobe after reset", pt_strobe, 0);

        wr(5'd0, 16'h1);
        wr(5'd1, 16'd40);
        wr(5'd3, 16'hFF);

        // R2 / R3: table of single-channel timing vectors
        for (int t = 0; t < TBL_N; t++) begin
            wr(5'(8 + TBL_CH[t]), 16'(TBL_DLY[t]));
            wr(5'd2, 16'(1 << TBL_CH[t]));
            wr(5'd0, 16'h5);
            start();
            scan(60, first, fidx, cnt);
            check(first == TBL_EXP[t], "R2", "first strobe edge", first, TBL_EXP[t]);
            if (TBL_EXP[t] != 0)
                check(fidx == TBL_CH[t], "R2", "strobe index", fidx, TBL_CH[t]);
            check(cnt == ((TBL_EXP[t] != 0) ? 1 : 0), "R3", "strobes per one-shot run",
                  cnt, (TBL_EXP[t] != 0) ? 1 : 0);
            settle();
        end

        // R6: load discarded while run enable clear; later accepted
        wr(5'd0, 16'h0);
        wr(5'd8, 16'd20);
        wr(5'd2, 16'h1);
        wr(5'd0, 16'h5);
        start();
        scan(30, first, fidx, cnt);
        check(first == 1, "R6", "old value kept after gated load", first, 1);
        settle();
        wr(5'd0, 16'h5);
        start();
        scan(30, first, fidx, cnt);
        check(first == 21, "R6", "new value after accepted load", first, 21);
        settle();

        // R4: enable and output enable both required
        wr(5'd3, 16'hFE);
        start();
        scan(30, first, fidx, cnt);
        check(cnt == 0, "R4", "strobes with output enable clear", cnt, 0);
        wr(5'd3, 16'hFF);
        wr(5'd2, 16'h0);
        start();
        scan(30, first, fidx, cnt);
        check(cnt == 0, "R4", "strobes with enable clear", cnt, 0);
        settle();

        // R9: equal compare values on channels 1 and 3
        wr(5'd9, 16'd5);
        wr(5'd11, 16'd5);
        wr(5'd2, 16'h0A);
        wr(5'd0, 16'h5);
        start();
        nk = 0;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (pt_strobe) begin
                if (k == 6) check(pt_idx == 3'd1, "R9", "index at edge 6", pt_idx, 1);
                if (k == 7) check(pt_idx == 3'd3, "R9", "index at edge 7", pt_idx, 3);
                nk++;
            end
        end
        check(nk == 2, "R9", "strobe count for tie", nk, 2);
        settle();

        // R5 / R10: channel 1 chained, channel 0 chain bit ignored
        wr(5'd8, 16'd3);
        wr(5'd9, 16'd3);
        wr(5'd2, 16'h3);
        wr(5'd4, 16'h3);
        wr(5'd0, 16'h5);
        start();
        scan(12, first, fidx, cnt);
        check(first == 4 && fidx == 0, "R10", "channel 0 fires on compare", first, 4);
        check(cnt == 1, "R5", "chained channel ignores compare", cnt, 1);
        pulse_done();
        check(pt_strobe == 1'b1 && pt_idx == 3'd1, "R5", "chained strobe after done",
              int'(pt_strobe) * 8 + int'(pt_idx), 9);
        @(negedge clk);
        check(pt_strobe == 1'b0, "R5", "chained strobe one cycle", pt_strobe, 0);
        check(seq_err == 1'b0, "R8", "no error on chained issue", seq_err, 0);
        settle();

        // R8: overlap sets sticky error; write-one clears
        wr(5'd8, 16'd2);
        wr(5'd9, 16'd4);
        wr(5'd0, 16'h5);
        start();
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 4) check(seq_err == 1'b0, "R8", "error before overlap", seq_err, 0);
            if (k == 5) check(seq_err == 1'b1, "R8", "error on overlap", seq_err, 1);
        end
        check(seq_err == 1'b1, "R8", "error sticky", seq_err, 1);
        wr(5'd5, 16'h0);
        check(seq_err == 1'b1, "R8", "write zero keeps error", seq_err, 1);
        wr(5'd5, 16'h1);
        check(seq_err == 1'b0, "R8", "write one clears error", seq_err, 0);
        settle();
        start();
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk); @(negedge clk);
            conv_done = (k == 3);
        end
        conv_done = 1'b0;
        check(seq_err == 1'b0, "R8", "no error when done in time", seq_err, 0);
        settle();

        // R7: continuous mode, modulus 9, channel 0 at 2
        wr(5'd1, 16'd9);
        wr(5'd2, 16'h1);
        wr(5'd0, 16'h3);
        wr(5'd0, 16'h7);
        start();
        nk = 0;
        for (int k = 1; k <= 35; k++) begin
            @(posedge clk); @(negedge clk);
            if (pt_strobe) begin
                if (nk < 4) ks[nk] = k;
                nk++;
            end
        end
        check(nk == 4, "R7", "strobes in continuous window", nk, 4);
        check(ks[0] == 3 && ks[3] == 33, "R7", "last continuous strobe edge", ks[3], 33);
        wr(5'd0, 16'h1);
        settle();

        // R1: restart mid-run
        wr(5'd1, 16'd40);
        wr(5'd8, 16'd6);
        wr(5'd0, 16'h5);
        start();
        scan(3, first, fidx, cnt);
        check(cnt == 0, "R1", "no strobe before restart", cnt, 0);
        start();
        scan(20, first, fidx, cnt);
        check(first == 7, "R1", "strobe counted from restart", first, 7);
        check(cnt == 1, "R1", "single strobe after restart", cnt, 1);
        settle();

        finish_run();
    end
endmodule